// File: doc/BRIEF.md
# Sequential Restoring Unsigned Divider

This block divides one unsigned word by another over many clock cycles, producing an unsigned quotient and remainder. A single wide shift register carries the partial remainder in its upper part and collects quotient bits at its lower end, so no separate quotient register is needed. One shared adder/subtractor performs a trial subtraction of the divisor per quotient bit; when the trial goes negative, the same adder adds the divisor back before the register shifts.

A caller presents both operands and pulses `start` while the block is idle. After a fixed number of cycles the block raises `done` for one cycle; `quotient` and `remainder` are valid at that point and stay unchanged until the next division completes. A zero divisor needs no special path: it yields an all-ones quotient and hands the dividend back as the remainder.

Top module: `rdiv_top`

## Requirements
- R1: A `start` sampled high while idle captures both operands; `done` is then seen high after exactly 2*WIDTH+2 rising edges counted from (and including) the edge that sampled `start` (66 for WIDTH=32).
- R2: For a non-zero divisor, `quotient` equals the unsigned integer quotient floor(dividend/divisor), e.g. 29/3 gives 9.
- R3: For a non-zero divisor, `remainder` equals dividend minus quotient times divisor and is strictly less than the divisor, e.g. 29/3 gives 2.
- R4: R2 and R3 hold over the full unsigned range, including divisors and dividends with the top bit set and divisors larger than the dividend.
- R5: A zero divisor gives a quotient of all ones and a remainder equal to the dividend.
- R6: `done` is high for exactly one cycle per completed division.
- R7: `quotient` and `remainder` keep their values from one `done` pulse until the next.
- R8: A `start` pulse while a division is in progress is ignored: the running division completes with its original operands and no extra `done` pulse follows.
- R9: While and just after reset, `done` is low and `quotient` and `remainder` are zero.
- R10: Before each trial subtraction, the upper part of the working register is below twice the divisor, so a single add-back always restores a negative trial.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a division (honoured only while idle) |
| dividend | input | WIDTH | Unsigned dividend, sampled with `start` |
| divisor | input | WIDTH | Unsigned divisor, sampled with `start` |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | WIDTH | Registered quotient |
| remainder | output | WIDTH | Registered remainder |

## Verification
Small worked cases such as 29/3, equal operands, a zero dividend and a divisor larger than the dividend separate the always-restore and never-restore paths of each step. Operands with the top bit set (all-ones over one, all-ones over the top bit alone, the top bit over all ones) expose a working register that is one bit too narrow or a borrow read from the wrong position. Zero divisors confirm the all-ones/dividend result, and a run of pseudo-random pairs compared against integer division catches bit-ordering slips in how quotient bits enter the register. A start pulse sent mid-division and idle gaps after completion check that operands are not re-captured and results are held.

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SUB,
    ST_CHK,
    ST_FIX
  } rdiv_state_e;
endpackage

// File: rtl/rdiv_seq.sv
// Step sequencer: idle, then WIDTH pairs of trial/decide cycles, then fix-up.
module rdiv_seq
  import rdiv_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic load,
  output logic sub_en,
  output logic chk_en,
  output logic fix_en,
  output logic done
);
  localparam int CW = $clog2(WIDTH) + 1;
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  rdiv_state_e state;
  logic [CW-1:0] step_cnt;

  assign load   = (state == ST_IDLE) && start;
  assign sub_en = (state == ST_SUB);
  assign chk_en = (state == ST_CHK);
  assign fix_en = (state == ST_FIX);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      step_cnt <= '0;
      done     <= 1'b0;
    end else begin
      done <= fix_en;
      unique case (state)
        ST_IDLE: if (start) begin
          state    <= ST_SUB;
          step_cnt <= '0;
        end
        ST_SUB: state <= ST_CHK;
        ST_CHK: begin
          if (step_cnt == LAST) begin
            state <= ST_FIX;
          end else begin
            state    <= ST_SUB;
            step_cnt <= step_cnt + 1'b1;
          end
        end
        ST_FIX: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_step_range_R1: assert property (@(posedge clk) disable iff (rst)
    step_cnt <= LAST);

  assert_fix_follows_chk_R1: assert property (@(posedge clk) disable iff (rst)
    fix_en |-> $past(chk_en));
endmodule

// File: rtl/rdiv_path.sv
// Working register, shared adder/subtractor and result registers.
module rdiv_path #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             sub_en,
  input  logic             chk_en,
  input  logic             fix_en,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder
);
  localparam int AW = 2 * WIDTH + 1;   // working register width
  localparam int HW = WIDTH + 1;       // upper (partial remainder) part

  logic [AW-1:0]    acc;
  logic [WIDTH-1:0] dvs;
  logic             neg_q;

  logic [HW-1:0]    upper;
  logic [WIDTH-1:0] lower;
  logic [HW:0]      addsub;

  assign upper = acc[AW-1:WIDTH];
  assign lower = acc[WIDTH-1:0];

  // One adder: subtracts during the trial cycle, adds back during the decide cycle.
  always_comb begin
    if (sub_en) addsub = {1'b0, upper} - {2'b00, dvs};
    else        addsub = {1'b0, upper} + {2'b00, dvs};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc       <= '0;
      dvs       <= '0;
      neg_q     <= 1'b0;
      quotient  <= '0;
      remainder <= '0;
    end else begin
      if (load) begin
        dvs <= divisor;
        acc <= {{HW{1'b0}}, dividend} << 1;
      end else if (sub_en) begin
        acc[AW-1:WIDTH] <= addsub[HW-1:0];
        neg_q           <= addsub[HW];
      end else if (chk_en) begin
        if (neg_q) acc <= {addsub[HW-2:0], lower, 1'b0};
        else       acc <= {acc[AW-2:0], 1'b1};
      end else if (fix_en) begin
        quotient  <= lower;
        remainder <= acc[AW-1:WIDTH+1];
      end
    end
  end

  assert_trial_bound_R10: assert property (@(posedge clk) disable iff (rst)
    (sub_en && dvs != '0) |-> (upper < {dvs, 1'b0}));

  assert_rem_bound_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(fix_en) && dvs != '0) |-> (remainder < dvs));

  assert_zero_div_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(fix_en) && dvs == '0) |-> (&quotient));
endmodule

// File: rtl/rdiv_top.sv
module rdiv_top #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic             done,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder
);
  logic load, sub_en, chk_en, fix_en;

  rdiv_seq #(.WIDTH(WIDTH)) u_seq (
    .clk(clk), .rst(rst), .start(start),
    .load(load), .sub_en(sub_en), .chk_en(chk_en), .fix_en(fix_en),
    .done(done)
  );

  rdiv_path #(.WIDTH(WIDTH)) u_path (
    .clk(clk), .rst(rst),
    .load(load), .sub_en(sub_en), .chk_en(chk_en), .fix_en(fix_en),
    .dividend(dividend), .divisor(divisor),
    .quotient(quotient), .remainder(remainder)
  );

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!done && !$past(fix_en)) |-> ($stable(quotient) && $stable(remainder)));
endmodule

// File: tb/rdiv_top_test.sv
module rdiv_top_test;
  localparam int W = 32;
  localparam int LAT = 2 * W + 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [W-1:0] dividend = '0;
  logic [W-1:0] divisor = '0;
  logic done;
  logic [W-1:0] quotient, remainder;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  logic [2*W-1:0] sb_q[$];
  logic [2*W-1:0] last_exp = '0;
  logic done_prev = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  rdiv_top #(.WIDTH(W)) uut (
    .clk(clk), .rst(rst), .start(start),
    .dividend(dividend), .divisor(divisor),
    .done(done), .quotient(quotient), .remainder(remainder)
  );

  task automatic chk(input bit ok, input string req, input logic [2*W-1:0] act,
                     input logic [2*W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on every done pulse (R2 R3 R4 R5 R6 R8).
  always @(negedge clk) begin
    if (!rst) begin
      if (done) begin
        chk(!done_prev, "R6 done width", {63'd0, done_prev}, 64'd0);
        if (sb_q.size() == 0) begin
          chk(1'b0, "R8 unexpected done", {quotient, remainder}, 64'd0);
        end else begin
          last_exp = sb_q.pop_front();
          chk({quotient, remainder} == last_exp, "R2/R3 result",
              {quotient, remainder}, last_exp);
        end
      end
      done_prev <= done;
    end
  end

  // Driver: pushes expectation, pulses start, measures latency (R1).
  task automatic run_div(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] eq, er;
    int n;
    eq = (b == 0) ? '1 : a / b;
    er = (b == 0) ? a : a % b;
    sb_q.push_back({eq, er});
    @(negedge clk);
    dividend = a; divisor = b; start = 1'b1;
    n = 0;
    @(posedge clk); n++;
    @(negedge clk); start = 1'b0;
    while (!done) begin
      @(posedge clk); n++;
      @(negedge clk);
    end
    chk(n == LAT, "R1 latency", 64'(n), 64'(LAT));
  endtask

  initial begin
    logic [W-1:0] lfsr;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(!done && quotient == 0 && remainder == 0, "R9 reset",
        {quotient, remainder}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(!done && quotient == 0 && remainder == 0, "R9 after reset",
        {quotient, remainder}, 64'd0);

    run_div(32'd29, 32'd3);                 // R2 R3 worked case
    chk(quotient == 9 && remainder == 2, "R2 R3 29/3",
        {quotient, remainder}, {32'd9, 32'd2});
    run_div(32'd0, 32'd5);
    run_div(32'd7, 32'd7);
    run_div(32'd5, 32'd7);                  // divisor larger: R4
    run_div(32'hFFFF_FFFF, 32'd1);          // R4
    run_div(32'hFFFF_FFFF, 32'h8000_0000);  // R4
    run_div(32'h8000_0000, 32'hFFFF_FFFF);  // R4
    run_div(32'hFFFF_FFFE, 32'hFFFF_FFFF);  // R4
    run_div(32'd1234, 32'd0);               // R5
    run_div(32'hFFFF_FFFF, 32'd0);          // R5

    // R7: outputs hold across idle cycles
    repeat (7) begin
      @(negedge clk);
      chk({quotient, remainder} == last_exp && !done, "R7 hold",
          {quotient, remainder}, last_exp);
    end

    // R8: start while busy is ignored
    sb_q.push_back({32'd14, 32'd2});
    @(negedge clk);
    dividend = 32'd100; divisor = 32'd7; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (5) @(negedge clk);
    dividend = 32'd9; divisor = 32'd2; start = 1'b1;
    @(negedge clk); start = 1'b0;
    dividend = 32'd0; divisor = 32'd0;
    repeat (LAT + 10) @(negedge clk);
    chk(quotient == 14 && remainder == 2, "R8 busy start ignored",
        {quotient, remainder}, {32'd14, 32'd2});

    // Pseudo-random pairs: R2 R3 R4
    lfsr = 32'hACE1_2345;
    for (int i = 0; i < 24; i++) begin
      logic [W-1:0] a, b;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      a = lfsr;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      b = lfsr >> (i % 31);
      run_div(a, b);
    end

    repeat (3) @(negedge clk);
    chk(sb_q.size() == 0, "R6 all results seen", 64'(sb_q.size()), 64'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  // Watchdog
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule